// File: doc/BRIEF.md
# Post-detection filter rate and power-down controller

This block drives a majority-vote noise filter that sits after an FSK demodulator. It takes the reference clock, an enable line and a two-bit rate select, and produces four outputs. The first is a one-cycle strobe that tells the filter when to take a sample. The second is a flag that halves the vote window. The third is a one-cycle clear pulse for the filter state. The fourth is an output-enable for the tri-state or open-drain data pin.

The rate select sets two things at once: the divisor applied to the reference clock, which is 4, 2 or 1, and the size of the vote window. When enable is low, the block emits no strobes, raises no clear pulse and releases the data pin. When enable returns high, a wake sequence issues the clear on the second clock edge that sees enable high. The divider then restarts at a fixed phase, so the first strobe comes at a known time.

All inputs are taken as already synchronous to the reference clock. The block uses one rising-edge clock domain, so the edge count of the wake sequence is a count of rising edges of `clk`.

Top module: `pdf_rate_ctrl`

## Requirements
- R1: With `rate_sel` = 2'b00 and the block running, `sample_stb` is high for one cycle out of every 4 (the default `DIV_SLOW`), and `half_win` is low.
- R2: With `rate_sel` = 2'b10 and the block running, `sample_stb` is high for one cycle out of every 2 (the default `DIV_MID`), and `half_win` is low.
- R3: With `rate_sel` = 2'b01 and the block running, `sample_stb` is high in every cycle and `half_win` is high. This code may be entered or left only while `en` is low.
- R4: With `rate_sel` = 2'b11 and the block running, `sample_stb` is high in every cycle and `half_win` is low.
- R5: `half_win` equals `en` AND `rate_sel[0]` AND NOT `rate_sel[1]`, combinationally, for every input combination.
- R6: While `en` is low, `sample_stb` and `filt_clr` stay low and the divider phase is held.
- R7: `out_oe` follows `en` combinationally: high drives the data pin, low releases it.
- R8: Counting rising edges from the first one that samples `en` high (edge 1), `filt_clr` is high for exactly one cycle, from edge 2 to edge 3. It is never high unless `en` was high at the previous edge.
- R9: The clear pulse resets the divider, so the first `sample_stb` comes in the cycle right after `filt_clr` falls. Strobes then recur at the period of the selected mode.
- R10: A synchronous active-high `rst` clears the divider and the wake sequence. While `rst` is high, `sample_stb` and `filt_clr` are low. After `rst` falls with `en` high, the R8 sequence runs again from edge 1.
- R11: Switching `rate_sel` among 2'b00, 2'b10 and 2'b11 while enabled raises no `filt_clr`. The strobe pattern of the new mode applies from the first edge after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low selects power-down |
| rate_sel | input | 2 | Rate and window select (bit 1, bit 0) |
| sample_stb | output | 1 | One-cycle sample strobe for the filter |
| half_win | output | 1 | Halve the vote window |
| filt_clr | output | 1 | One-cycle clear of the filter state after wake-up |
| out_oe | output | 1 | Output-enable for the data pin |

## Verification
The assertions assume that `rate_sel` never moves into or out of code 2'b01 across two consecutive edges where `en` is high. One of them checks this assumption directly. The stimulus respects it: every change that involves code 2'b01 is made while `en` is low, including the combinational sweep of `half_win`, which raises `en` for only one cycle per code. Strobe-phase checks also assume that `rst` is not applied during the cycle the clear pulse ends. The bench never applies `rst` at that point.

// File: rtl/pdf_ctrl_pkg.sv
package pdf_ctrl_pkg;

    localparam int DIV_W = 8;

    typedef enum logic [1:0] {
        MODE_SLOW      = 2'b00,
        MODE_FAST_HALF = 2'b01,
        MODE_MID       = 2'b10,
        MODE_FAST      = 2'b11
    } rate_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             half;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(
        input logic [1:0]       sel,
        input logic [DIV_W-1:0] d_slow,
        input logic [DIV_W-1:0] d_mid
    );
        mode_cfg_t c;
        case (rate_mode_e'(sel))
            MODE_SLOW:      begin c.div = d_slow;           c.half = 1'b0; end
            MODE_MID:       begin c.div = d_mid;            c.half = 1'b0; end
            MODE_FAST_HALF: begin c.div = DIV_W'(1);        c.half = 1'b1; end
            default:        begin c.div = DIV_W'(1);        c.half = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pdf_mode_decode.sv
module pdf_mode_decode
    import pdf_ctrl_pkg::*;
#(
    parameter int DIV_SLOW = 4,
    parameter int DIV_MID  = 2
) (
    input  logic       en,
    input  logic [1:0] sel,
    output mode_cfg_t  cfg,
    output logic       half_win
);
    localparam logic [DIV_W-1:0] D_SLOW = DIV_W'(DIV_SLOW);
    localparam logic [DIV_W-1:0] D_MID  = DIV_W'(DIV_MID);

    always_comb begin
        cfg      = decode_mode(sel, D_SLOW, D_MID);
        half_win = en & cfg.half;
    end
endmodule

// File: rtl/pdf_wake_seq.sv
module pdf_wake_seq #(
    parameter int WAKE_EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic clr,
    output logic run
);
    localparam int WW = $clog2(WAKE_EDGES + 1);
    localparam logic [WW-1:0] LAST = WW'(WAKE_EDGES);
    localparam logic [WW-1:0] FIRE = WW'(WAKE_EDGES - 1);

    logic [WW-1:0] cnt_q;
    logic          clr_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= (cnt_q == FIRE);
            if (cnt_q != LAST)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clr = clr_q;
    assign run = en && (cnt_q == LAST) && !clr_q;

    // R8
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> !clr_q);

    // R8
    clr_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q |-> $past(en));
endmodule

// File: rtl/pdf_rate_div.sv
module pdf_rate_div
    import pdf_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= (cnt_q >= div - 1'b1) ? '0 : cnt_q + 1'b1;
    end

    assign stb = run && (cnt_q == '0);

    // R1
    slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && div > DIV_W'(1)) |=> !stb);
endmodule

// File: rtl/pdf_rate_ctrl.sv
module pdf_rate_ctrl
    import pdf_ctrl_pkg::*;
#(
    parameter int DIV_SLOW   = 4,
    parameter int DIV_MID    = 2,
    parameter int WAKE_EDGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       sample_stb,
    output logic       half_win,
    output logic       filt_clr,
    output logic       out_oe
);
    mode_cfg_t cfg;
    logic      run;

    pdf_mode_decode #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID)) u_dec (
        .en       (en),
        .sel      (rate_sel),
        .cfg      (cfg),
        .half_win (half_win)
    );

    pdf_wake_seq #(.WAKE_EDGES(WAKE_EDGES)) u_wake (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .clr (filt_clr),
        .run (run)
    );

    pdf_rate_div u_div (
        .clk   (clk),
        .rst   (rst),
        .clear (filt_clr),
        .run   (run),
        .div   (cfg.div),
        .stb   (sample_stb)
    );

    assign out_oe = en;

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!sample_stb && !filt_clr));

    // R9
    first_stb_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(filt_clr) && en && !$past(rst)) |-> sample_stb);

    // R3
    half_mode_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> ((rate_sel == 2'b01) == ($past(rate_sel) == 2'b01)));
endmodule

// File: tb/pdf_rate_ctrl_test.sv
module pdf_rate_ctrl_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       sample_stb, half_win, filt_clr, out_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pdf_rate_ctrl uut (
        .clk(clk), .rst(rst), .en(en), .rate_sel(rate_sel),
        .sample_stb(sample_stb), .half_win(half_win),
        .filt_clr(filt_clr), .out_oe(out_oe)
    );

    function automatic int divisor(input int m);
        case (m)
            0: return 4;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R1";
            2: return "R2";
            1: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // Observe the wake sequence: edge k=1 is the first edge sampling en high.
    task automatic observe(input int m, input int ncyc);
        int dv = divisor(m);
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R8", filt_clr, k == 2);
            chk((k == 3) ? "R9" : mode_tag(m), sample_stb, (k >= 3) && ((k - 3) % dv == 0));
            chk("R5", half_win, m == 1);
            chk("R7", out_oe, 1'b1);
        end
    endtask

    task automatic wake(input int m, input int ncyc);
        @(negedge clk);
        en = 1'b0;
        rate_sel = 2'(m);
        @(negedge clk);
        en = 1'b1;
        observe(m, ncyc);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", sample_stb, 1'b0);
        chk("R10", filt_clr, 1'b0);
        chk("R7", out_oe, 1'b0);
        rst = 1'b0;

        // R1 R2 R3 R4 per-mode wake and period
        wake(0, 20);
        wake(2, 20);
        wake(1, 20);
        wake(3, 20);

        // R6 power-down: quiet outputs, then a fresh wake
        @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R6", sample_stb, 1'b0);
            chk("R6", filt_clr, 1'b0);
            chk("R7", out_oe, 1'b0);
            chk("R5", half_win, 1'b0);
        end
        en = 1'b1;
        observe(3, 10);

        // R10 reset while running restarts the sequence
        wake(0, 10);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10", sample_stb, 1'b0);
        chk("R10", filt_clr, 1'b0);
        rst = 1'b0;
        observe(0, 14);

        // R11 mode switches while enabled
        rate_sel = 2'b11;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R11", sample_stb, 1'b1);
            chk("R11", filt_clr, 1'b0);
        end
        rate_sel = 2'b10;
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (sample_stb) cnt++;
            chk("R11", filt_clr, 1'b0);
        end
        checks++;
        if (cnt != 4) begin
            failures++;
            $display("FAIL R11 act=%0d exp=4 strobes in mid mode", cnt);
        end
        rate_sel = 2'b00;
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (sample_stb) cnt++;
            chk("R11", filt_clr, 1'b0);
        end
        checks++;
        if (cnt != 2) begin
            failures++;
            $display("FAIL R11 act=%0d exp=2 strobes in slow mode", cnt);
        end

        // R5 and R7 combinational sweep, mode changes only with en low
        for (int s = 0; s < 4; s++) begin
            en = 1'b0;
            rate_sel = 2'(s);
            #1;
            chk("R5", half_win, 1'b0);
            chk("R7", out_oe, 1'b0);
            en = 1'b1;
            #1;
            chk("R5", half_win, (s == 1));
            chk("R7", out_oe, 1'b1);
            @(negedge clk);
            en = 1'b0;
            @(negedge clk);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule